// File: doc/BRIEF.md
# Four-Wire Serial Host Slave

This block is the byte-level front end of a full-duplex serial control port in which an external host owns the clock. The host pulls an active-low select line, toggles the serial clock and presents one command byte on the data-in pin, most significant bit first. In the same transfer, the block returns a response byte that the core supplied in parallel. When the select line is released, the received byte goes to the core with a one-cycle strobe.

All three host pins are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. The system clock must therefore run at least four times faster than the serial clock. The data-out pin is modelled as a level plus an output enable, so a pad cell can tri-state it. Transfers shorter or longer than a byte have a defined result. A short transfer delivers its bits packed toward the least significant end. A long transfer keeps the most recent eight bits, and once the response byte has been sent the output plays back the bits already received.

Top module: `serial_host_slave`

## Requirements
- R1: After reset, `sdo_oe_o`, `sdo_o` and `rx_valid_o` are 0 and `rx_byte_o` is 8'h00.
- R2: `sdo_oe_o` is 1 while the synchronized select line is low and 0 while it is high. It follows the select pin after a fixed synchronizer latency.
- R3: On the select falling edge, `tx_byte_i` is loaded and its bit 7 appears on `sdo_o` before any serial clock edge.
- R4: `sdi_i` is sampled on serial clock rising edges, first bit received as the most significant. After exactly 8 clocks, `rx_byte_o` equals the 8 sampled bits.
- R5: `sdo_o` advances to the next response bit on each serial clock falling edge, sending bit 7 down to bit 0.
- R6: With N < 8 clocks, `rx_byte_o` holds the N received bits in bits N-1..0 and zeros above them.
- R7: With more than 8 clocks, `rx_byte_o` holds the last 8 bits received.
- R8: After the 8 response bits, `sdo_o` sends the bits received on `sdi_i`, in arrival order, delayed by 8 clocks, until select rises.
- R9: On the select rising edge, `rx_valid_o` pulses high for exactly one system clock if at least one serial clock rose during the transfer, and does not pulse otherwise.
- R10: `sdo_o` is 0 whenever `sdo_oe_o` is 0.
- R11: Serial clock and data activity while select is high changes neither `rx_byte_o`, `rx_valid_o` nor `sdo_oe_o`.
- R12: `rx_byte_o` changes only in the cycle `rx_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from host (asynchronous) |
| ss_ni | input | 1 | Active-low select from host (asynchronous) |
| sdi_i | input | 1 | Serial data from host (asynchronous) |
| tx_byte_i | input | 8 | Response byte from the core, loaded at select fall |
| sdo_o | output | 1 | Serial data level toward host |
| sdo_oe_o | output | 1 | Drive enable for the data-out pad |
| rx_byte_o | output | 8 | Last byte received, held between transfers |
| rx_valid_o | output | 1 | One-cycle strobe when a received byte is delivered |

## Verification
A corrupted shift register shows on `sdo_o` at the next host sampling point, which is within one serial clock period. A corrupted received byte shows only at deselect, as a wrong `rx_byte_o` beside the strobe. A stuck transfer-seen flag shows as a missing or extra strobe on empty transfers. A wrong select state shows on `sdo_oe_o` a few system clocks after the select pin moves. The bench model runs beside the design and flags any of these in the first clock where the ports diverge.

// File: rtl/shs_pkg.sv
package shs_pkg;
  localparam int BYTE_W      = 8;
  localparam int SYNC_STAGES = 2;
  localparam int PIN_W       = 3;
  localparam int SCK_IDX     = 0;
  localparam int SS_IDX      = 1;
  localparam int SDI_IDX     = 2;
  // Reset levels of the host pins: select idles high (deselected)
  localparam logic [PIN_W-1:0] PIN_IDLE = 3'b010;
endpackage

// File: rtl/shs_sync.sv
module shs_sync #(
  parameter int            W      = 3,
  parameter int            STAGES = 2,
  parameter logic [W-1:0]  RST_V  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_V;
      else         stg_q[s] <= src;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/shs_edge.sv
module shs_edge #(
  parameter int           W     = 2,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_V;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/shs_shifter.sv
module shs_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ss_lvl_i,
  input  logic         ss_rise_i,
  input  logic         ss_fall_i,
  input  logic         sck_rise_i,
  input  logic         sck_fall_i,
  input  logic         sdi_i,
  input  logic [W-1:0] tx_byte_i,
  output logic         sdo_o,
  output logic         sdo_oe_o,
  output logic [W-1:0] rx_byte_o,
  output logic         rx_valid_o
);
  logic [W-1:0] tx_q, tx_d;
  logic [W-1:0] rx_q, rx_d;
  logic [W-1:0] byte_q, byte_d;
  logic         seen_q, seen_d;
  logic         oe_q, oe_d;
  logic         vld_q, vld_d;
  logic         shift_en;

  assign shift_en = oe_q & ~ss_lvl_i;

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    byte_d = byte_q;
    seen_d = seen_q;
    oe_d   = oe_q;
    vld_d  = 1'b0;
    if (ss_fall_i) begin
      oe_d   = 1'b1;
      tx_d   = tx_byte_i;
      rx_d   = '0;
      seen_d = 1'b0;
    end else if (ss_rise_i) begin
      oe_d   = 1'b0;
      seen_d = 1'b0;
      if (seen_q) begin
        byte_d = rx_q;
        vld_d  = 1'b1;
      end
    end else if (shift_en) begin
      if (sck_rise_i) begin
        rx_d   = {rx_q[W-2:0], sdi_i};
        seen_d = 1'b1;
      end else if (sck_fall_i) begin
        // newest received bit joins the tail: echo after the response
        tx_d = {tx_q[W-2:0], rx_q[0]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      byte_q <= '0;
      seen_q <= 1'b0;
      oe_q   <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      byte_q <= byte_d;
      seen_q <= seen_d;
      oe_q   <= oe_d;
      vld_q  <= vld_d;
    end
  end

  assign sdo_o      = oe_q & tx_q[W-1];
  assign sdo_oe_o   = oe_q;
  assign rx_byte_o  = byte_q;
  assign rx_valid_o = vld_q;
endmodule

// File: rtl/serial_host_slave.sv
module serial_host_slave
  import shs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              sdi_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o
);
  logic [PIN_W-1:0] pins_raw, pins_sync;
  logic [1:0]       rise, fall;
  logic             ss_sync;

  assign pins_raw[SCK_IDX] = sck_i;
  assign pins_raw[SS_IDX]  = ss_ni;
  assign pins_raw[SDI_IDX] = sdi_i;

  shs_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_V(PIN_IDLE)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_raw), .q_o(pins_sync)
  );

  shs_edge #(.W(2), .RST_V(PIN_IDLE[1:0])) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(pins_sync[1:0]),
    .rise_o(rise), .fall_o(fall)
  );

  assign ss_sync = pins_sync[SS_IDX];

  shs_shifter #(.W(BYTE_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ss_lvl_i(ss_sync), .ss_rise_i(rise[SS_IDX]), .ss_fall_i(fall[SS_IDX]),
    .sck_rise_i(rise[SCK_IDX]), .sck_fall_i(fall[SCK_IDX]),
    .sdi_i(pins_sync[SDI_IDX]), .tx_byte_i(tx_byte_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o)
  );
endmodule

// File: rtl/serial_host_slave_chk.sv
module serial_host_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ss_s,
  input logic       sdo,
  input logic       sdo_oe,
  input logic [7:0] rx_byte,
  input logic       rx_valid
);
  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R9
  strobe_at_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!sdo_oe && ss_s));
  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
  // R12
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(rx_byte) || rx_valid);
  // R2
  oe_follows_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !ss_s);
  // R2
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe) |-> ss_s);
endmodule

bind serial_host_slave serial_host_slave_chk u_chk (
  .clk(clk_i), .rst_n(rst_ni), .ss_s(ss_sync), .sdo(sdo_o),
  .sdo_oe(sdo_oe_o), .rx_byte(rx_byte_o), .rx_valid(rx_valid_o)
);

// File: tb/serial_host_slave_bench.sv
`timescale 1ns/1ps
module serial_host_slave_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, ss_n = 1'b1, sdi = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       sdo, sdo_oe, rx_valid;
  logic [7:0] rx_byte;

  int total = 0, fails = 0, pulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_host_slave u_serial_host_slave (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ss_ni(ss_n), .sdi_i(sdi),
    .tx_byte_i(tx_byte), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit hs[$], hk[$], hd[$];
  bit outq[$];
  bit m_oe, m_seen, m_vld;
  logic [7:0] m_rx, m_byte;

  always @(posedge clk) begin
    if (!rst_n) begin
      hs = '{1, 1, 1, 1}; hk = '{0, 0, 0, 0}; hd = '{0, 0, 0, 0};
      outq = {}; m_oe = 0; m_seen = 0; m_vld = 0; m_rx = 0; m_byte = 0;
    end else begin
      hs.push_front(ss_n); hs.delete(4);
      hk.push_front(sck);  hk.delete(4);
      hd.push_front(sdi);  hd.delete(4);
      m_vld = 0;
      if (!hs[2] && hs[3]) begin
        m_oe = 1; m_seen = 0; m_rx = 0; outq = {};
        for (int i = 7; i >= 0; i--) outq.push_back(tx_byte[i]);
      end else if (hs[2] && !hs[3]) begin
        if (m_seen) begin m_byte = m_rx; m_vld = 1; end
        m_oe = 0; m_seen = 0;
      end else if (m_oe && !hs[2]) begin
        if (hk[2] && !hk[3]) begin
          m_rx = {m_rx[6:0], hd[2]}; m_seen = 1;
        end else if (!hk[2] && hk[3]) begin
          void'(outq.pop_front()); outq.push_back(m_rx[0]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 oe", sdo_oe, m_oe);
      check("R5/R10 sdo", sdo, (m_oe && outq.size() > 0) ? outq[0] : 1'b0);
      check("R9 strobe", rx_valid, m_vld);
      check("R12 rx_byte", rx_byte, m_byte);
      if (rx_valid) pulses++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int n, input logic [31:0] din,
                      output logic [31:0] got);
    got = 0;
    tx_byte = tx;
    sdi = (n > 0) ? din[n-1] : 1'b0;
    ss_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      wait_clk(8);
      got = {got[30:0], sdo};
      check("R2 oe during transfer", sdo_oe, 1'b1);
      sck = 1'b1;
      wait_clk(8);
      sck = 1'b0;
      sdi = (i + 1 < n) ? din[n-2-i] : 1'b0;
    end
    wait_clk(8);
    ss_n = 1'b1;
    wait_clk(8);
    check("R2 oe after deselect", sdo_oe, 1'b0);
  endtask

  initial begin
    logic [31:0] got;
    logic [7:0]  held;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(1);
    // R1
    check("R1 oe", sdo_oe, 0);
    check("R1 sdo", sdo, 0);
    check("R1 valid", rx_valid, 0);
    check("R1 rx_byte", rx_byte, 0);

    // R3 R5 R4 R9: full byte
    pulses = 0;
    xfer(8'hA5, 8, 32'h3C, got);
    check("R3/R5 response stream", got[7:0], 8'hA5);
    check("R4 rx byte", rx_byte, 8'h3C);
    check("R9 one strobe", pulses, 1);

    // R3: first bit visible before any clock
    tx_byte = 8'h80; ss_n = 1'b0; wait_clk(8);
    check("R3 msb before clock", sdo, 1'b1);
    ss_n = 1'b1; wait_clk(8);

    // R6: short transfer right-aligned
    xfer(8'hC3, 3, 32'h5, got);
    check("R6 short rx", rx_byte, 8'h05);
    check("R5 short stream", got[2:0], 3'b110);

    // R7 R8: long transfer
    xfer(8'h5A, 12, 32'hABC, got);
    check("R7 last eight", rx_byte, 8'hBC);
    check("R8 echo after response", got[11:0], 12'h5AA);
    xfer(8'hFF, 16, 32'h1234, got);
    check("R8 full echo", got[15:0], 16'hFF12);
    check("R7 last eight 16", rx_byte, 8'h34);

    // R9: empty transfer -> no strobe, byte held
    pulses = 0; held = rx_byte;
    xfer(8'h00, 0, 32'h0, got);
    check("R9 no strobe on empty", pulses, 0);
    check("R9 byte held on empty", rx_byte, held);

    // R11: activity while deselected
    pulses = 0;
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1; sck = 1'b1; wait_clk(8);
      check("R11 oe stays low", sdo_oe, 0);
      sck = 1'b0; wait_clk(8);
    end
    check("R11 byte unchanged", rx_byte, held);
    check("R11 no strobe", pulses, 0);
    check("R10 sdo idle", sdo, 0);

    wait_clk(4);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule